// File: doc/BRIEF.md
# Two-Level I/O Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address for one of four address spaces. Every accepted request performs a complete two-step walk through tables held in memory. The first read fetches a directory entry selected by the top ten address bits. The second read fetches a leaf entry selected by the next ten bits. The 12-bit page offset passes through unchanged. Nothing is cached, so each request costs its two memory reads, or fewer when it faults early.

Each address space has its own directory base word, programmed through an indirect pair of configuration registers. One write picks the address space and a second write stores the base word for it. A base word of zero marks an address space without a directory. Directory entries, leaf entries and base words share one layout: a 20-bit page frame in bits 19:0, readable in bit 31, writable in bit 30 and non-secure in bit 29. In directory entries, bit 28 says that a second-level table is present.

Only one walk is in flight at a time. The request is held in a register until its one-cycle response has been given, and the block does not accept a new request before then.

Top module: `iova_walker`

## Requirements
- R1: After reset reqReady is 1, rspValid and memRdEn are 0, and all four directory base words are zero, so any request faults.
- R2: A configuration write with cfgSel=0 loads the address-space select from cfgWrData[1:0] and changes no base word. A write with cfgSel=1 stores cfgWrData as the base word of the selected address space only.
- R3: A request on an address space whose base word is zero returns rspFault=1 and issues no memory read.
- R4: The first read address is the base frame (bits 19:0) shifted left by 12, plus four times virtual address bits 31:22.
- R5: A directory entry with bit 28 clear is vacant: the response faults and no second read is issued.
- R6: The second read address is the directory entry frame (bits 19:0) shifted left by 12, plus four times virtual address bits 21:12.
- R7: A successful response gives rspPhys = {leaf entry bits 19:0, virtual address bits 11:0} with rspFault=0.
- R8: A read request (reqWrite=0) needs bit 31 set in both the directory entry and the leaf entry, and a write request needs bit 30 set in both. A failure at the directory level faults without a second read. Bit 29 has no effect on translation.
- R9: Once a request is accepted, reqReady stays low until after the response. rspValid is a single-cycle pulse, and a faulted response carries rspPhys = 0.
- R10: memRdEn stays high with an unchanged memRdAddr until the cycle in which memRdValid is high, whatever the memory latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle, request accepted this cycle |
| reqAddr | input | 32 | Virtual address to translate |
| reqAsid | input | 2 | Address space of the request |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 = address-space select, 1 = base word of selected space |
| cfgWrData | input | 32 | Configuration write data |
| memRdEn | output | 1 | Table entry read request, held until memRdValid |
| memRdAddr | output | 32 | Byte address of the entry to read |
| memRdValid | input | 1 | Read data valid, ends the read |
| memRdData | input | 32 | Table entry read from memory |
| rspValid | output | 1 | One-cycle response strobe |
| rspFault | output | 1 | Translation failed |
| rspPhys | output | 32 | Physical address, zero on fault |

## Verification
Three kinds of fault are hard to tell apart from the ports, because they all end in the same flag. A walk stopped by a directory-level permission failure has to be separated from one stopped by a leaf-level failure. Both have to be separated from a walk that never starts because the base word is zero. The bench builds a memory image with a read-only directory entry, a table whose leaf lacks read permission, and an address space whose directory area is empty. Its memory model logs every read address, so each fault is checked both by its flag and by how many reads came before it and at which addresses. The held read under a stalled memory is reached by raising the model's latency to several cycles for a repeated walk.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int VA_W       = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int IDX_W      = 10;
  localparam int FRAME_W    = 20;
  localparam int NUM_ASID   = 4;
  localparam int ASID_W     = $clog2(NUM_ASID);
  localparam int BIT_RD     = 31;
  localparam int BIT_WR     = 30;
  localparam int BIT_NS     = 29;
  localparam int BIT_NEXT   = 28;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic tblPhase;
    logic latchPde;
    logic latchRsp;
    logic rspFault;
  } walkCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic baseZero;
    logic entryNext;
    logic entryPermOk;
  } walkSts_t;
endpackage

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  walkCtl_t          ctl,
  output walkSts_t          sts,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic              reqWrite,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [VA_W-1:0]   cfgWrData,
  input  logic [VA_W-1:0]   memRdData,
  output logic [VA_W-1:0]   memRdAddr,
  output logic              rspFault,
  output logic [VA_W-1:0]   rspPhys
);
  logic [VA_W-1:0]    baseReg [NUM_ASID];
  logic [ASID_W-1:0]  selReg;
  logic [VA_W-1:0]    heldAddr;
  logic [ASID_W-1:0]  heldAsid;
  logic               heldWrite;
  logic [FRAME_W-1:0] pdeFrame;

  logic [IDX_W-1:0]   dirIdx, tblIdx, curIdx;
  logic [FRAME_W-1:0] tableFrame;
  logic               unusedBits;

  // indirect select/data configuration pair
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selReg <= '0;
      for (int i = 0; i < NUM_ASID; i++) baseReg[i] <= '0;
    end else if (cfgWrEn) begin
      if (!cfgSel) selReg <= cfgWrData[ASID_W-1:0];
      else         baseReg[selReg] <= cfgWrData;
    end
  end

  // request holding and directory entry capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      heldAddr  <= '0;
      heldAsid  <= '0;
      heldWrite <= 1'b0;
      pdeFrame  <= '0;
    end else begin
      if (ctl.accept) begin
        heldAddr  <= reqAddr;
        heldAsid  <= reqAsid;
        heldWrite <= reqWrite;
      end
      if (ctl.latchPde) pdeFrame <= memRdData[FRAME_W-1:0];
    end
  end

  assign dirIdx     = heldAddr[VA_W-1 -: IDX_W];
  assign tblIdx     = heldAddr[PAGE_SHIFT+IDX_W-1 -: IDX_W];
  assign curIdx     = ctl.tblPhase ? tblIdx : dirIdx;
  assign tableFrame = ctl.tblPhase ? pdeFrame : baseReg[heldAsid][FRAME_W-1:0];
  assign memRdAddr  = {tableFrame, {PAGE_SHIFT{1'b0}}} + (VA_W'(curIdx) << 2);

  assign sts.baseZero    = (baseReg[heldAsid] == '0);
  assign sts.entryNext   = memRdData[BIT_NEXT];
  assign sts.entryPermOk = heldWrite ? memRdData[BIT_WR] : memRdData[BIT_RD];

  // non-secure and spare entry bits take no part in translation
  assign unusedBits = ^{memRdData[BIT_NS], memRdData[BIT_NEXT-1:FRAME_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspFault <= 1'b0;
      rspPhys  <= '0;
    end else if (ctl.latchRsp) begin
      rspFault <= ctl.rspFault;
      rspPhys  <= ctl.rspFault ? '0
                : {memRdData[FRAME_W-1:0], heldAddr[PAGE_SHIFT-1:0]};
    end
  end
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reqValid,
  output logic     reqReady,
  input  logic     memRdValid,
  output logic     memRdEn,
  output logic     rspValid,
  input  walkSts_t sts,
  output walkCtl_t ctl
);
  typedef enum logic [1:0] {S_IDLE, S_DIR, S_TBL, S_RSP} walkState_t;
  walkState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    reqReady  = 1'b0;
    memRdEn   = 1'b0;
    rspValid  = 1'b0;
    case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.accept = 1'b1;
          nextState  = S_DIR;
        end
      end
      S_DIR: begin
        if (sts.baseZero) begin
          ctl.latchRsp = 1'b1;
          ctl.rspFault = 1'b1;
          nextState    = S_RSP;
        end else begin
          memRdEn = 1'b1;
          if (memRdValid) begin
            if (!sts.entryNext || !sts.entryPermOk) begin
              ctl.latchRsp = 1'b1;
              ctl.rspFault = 1'b1;
              nextState    = S_RSP;
            end else begin
              ctl.latchPde = 1'b1;
              nextState    = S_TBL;
            end
          end
        end
      end
      S_TBL: begin
        ctl.tblPhase = 1'b1;
        memRdEn      = 1'b1;
        if (memRdValid) begin
          ctl.latchRsp = 1'b1;
          ctl.rspFault = !sts.entryPermOk;
          nextState    = S_RSP;
        end
      end
      default: begin
        rspValid  = 1'b1;
        nextState = S_IDLE;
      end
    endcase
  end
endmodule

// File: rtl/iova_walker.sv
module iova_walker
  import walk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic              reqWrite,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [VA_W-1:0]   cfgWrData,
  output logic              memRdEn,
  output logic [VA_W-1:0]   memRdAddr,
  input  logic              memRdValid,
  input  logic [VA_W-1:0]   memRdData,
  output logic              rspValid,
  output logic              rspFault,
  output logic [VA_W-1:0]   rspPhys
);
  walkCtl_t ctl;
  walkSts_t sts;

  walk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .memRdValid(memRdValid), .memRdEn(memRdEn), .rspValid(rspValid),
    .sts(sts), .ctl(ctl)
  );

  walk_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .sts(sts),
    .reqAddr(reqAddr), .reqAsid(reqAsid), .reqWrite(reqWrite),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .memRdData(memRdData), .memRdAddr(memRdAddr),
    .rspFault(rspFault), .rspPhys(rspPhys)
  );
endmodule

// File: rtl/iova_walker_chk.sv
module iova_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reqValid,
  input logic        reqReady,
  input logic [31:0] reqAddr,
  input logic        memRdEn,
  input logic [31:0] memRdAddr,
  input logic        memRdValid,
  input logic        rspValid,
  input logic        rspFault,
  input logic [31:0] rspPhys
);
  logic [11:0] heldOff;
  logic        unusedHi;
  assign unusedHi = ^reqAddr[31:12];

  always_ff @(posedge clk) begin
    if (!rst_n) heldOff <= '0;
    else if (reqValid && reqReady) heldOff <= reqAddr[11:0];
  end

  // R9: single-cycle response strobe
  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !rspValid);

  // R9: no second acceptance while a walk is open
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady);

  // R9: faulted responses carry a zero address
  p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspFault) |-> (rspPhys == 32'h0));

  // R7: page offset of the accepted request passes through
  p_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !rspFault) |-> (rspPhys[11:0] == heldOff));

  // R10: a read is held with a stable address until data returns
  p_hold_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (memRdEn && !memRdValid) |=> (memRdEn && $stable(memRdAddr)));

  // R10: no memory read while idle
  p_idle_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> !memRdEn);
endmodule

bind iova_walker iova_walker_chk u_chk (.*);

// File: tb/test_iova_walker.sv
`timescale 1ns/1ps
module test_iova_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqAsid = '0;
  logic        reqWrite = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        memRdEn;
  logic [31:0] memRdAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        rspValid, rspFault;
  logic [31:0] rspPhys;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  iova_walker i_iova_walker (.*);

  // memory model with programmable latency and a read log
  logic [31:0] memImg [logic [31:0]];
  logic [31:0] rdLog [64];
  int rdTotal = 0;
  int memWait = 0;
  int waitCnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      memRdValid <= 1'b0;
      waitCnt    <= 0;
    end else if (memRdEn && !memRdValid) begin
      if (waitCnt >= memWait) begin
        memRdValid <= 1'b1;
        memRdData  <= memImg.exists(memRdAddr) ? memImg[memRdAddr] : 32'h0;
        rdLog[rdTotal % 64] <= memRdAddr;
        rdTotal    <= rdTotal + 1;
        waitCnt    <= 0;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end else begin
      memRdValid <= 1'b0;
    end
  end

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  asid;
    logic        wr;
    logic        fault;
    logic [31:0] phys;
    logic [1:0]  nRd;
    logic [31:0] rd0;
    logic [31:0] rd1;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VEC [NVEC] = '{
    '{32'h0040_5123, 2'd0, 1'b0, 1'b0, 32'hABCD_E123, 2'd2, 32'h0001_0004, 32'h0004_0014},
    '{32'h0040_5123, 2'd0, 1'b1, 1'b0, 32'hABCD_E123, 2'd2, 32'h0001_0004, 32'h0004_0014},
    '{32'h007F_FFFF, 2'd0, 1'b0, 1'b0, 32'h1234_5FFF, 2'd2, 32'h0001_0004, 32'h0004_0FFC},
    '{32'h007F_FFFF, 2'd0, 1'b1, 1'b1, 32'h0000_0000, 2'd2, 32'h0001_0004, 32'h0004_0FFC},
    '{32'hFFC0_0000, 2'd0, 1'b0, 1'b1, 32'h0000_0000, 2'd1, 32'h0001_0FFC, 32'h0},
    '{32'h0080_0ABC, 2'd0, 1'b0, 1'b0, 32'h0077_7ABC, 2'd2, 32'h0001_0008, 32'h0004_1000},
    '{32'h0080_0ABC, 2'd0, 1'b1, 1'b1, 32'h0000_0000, 2'd1, 32'h0001_0008, 32'h0},
    '{32'h0040_5123, 2'd1, 1'b0, 1'b1, 32'h0000_0000, 2'd2, 32'h0002_0004, 32'h0005_0014},
    '{32'h0040_5123, 2'd1, 1'b1, 1'b0, 32'h0099_9123, 2'd2, 32'h0002_0004, 32'h0005_0014},
    '{32'h0040_5123, 2'd2, 1'b0, 1'b1, 32'h0000_0000, 2'd1, 32'h0003_0004, 32'h0},
    '{32'h0040_5123, 2'd3, 1'b0, 1'b1, 32'h0000_0000, 2'd0, 32'h0,         32'h0}
  };

  task automatic check(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic sel, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic setBase(input logic [1:0] asid, input logic [31:0] word);
    cfgWrite(1'b0, {30'h0, asid});
    cfgWrite(1'b1, word);
  endtask

  // one walk; returns the response and the number of reads it caused
  task automatic walk(input logic [31:0] va, input logic [1:0] asid, input logic wr,
                      output logic fault, output logic [31:0] phys,
                      output int nRd, output int firstRd);
    int wd = 0;
    @(negedge clk);
    firstRd = rdTotal;
    reqAddr = va; reqAsid = asid; reqWrite = wr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R9 ready low during walk", {31'h0, reqReady}, 32'h0);
    while (!rspValid && wd < 500) begin
      @(negedge clk);
      wd++;
    end
    check(rspValid == 1'b1, "R9 response arrives", {31'h0, rspValid}, 32'h1);
    fault = rspFault;
    phys  = rspPhys;
    nRd   = rdTotal - firstRd;
    @(negedge clk);
    check(rspValid == 1'b0 && reqReady == 1'b1, "R9 pulse then ready",
          {30'h0, rspValid, reqReady}, 32'h1);
  endtask

  initial begin
    logic f;
    logic [31:0] p;
    int n, first;

    // page tables in memory
    memImg[32'h0001_0004] = 32'hF000_0040;  // dir0[1]: R W NS next -> 0x40
    memImg[32'h0001_0008] = 32'h9000_0041;  // dir0[2]: read-only next -> 0x41
    memImg[32'h0001_0FFC] = 32'hE000_0041;  // dir0[3FF]: no next bit (vacant)
    memImg[32'h0002_0004] = 32'hF000_0050;  // dir1[1] -> 0x50
    memImg[32'h0004_0014] = 32'hE00A_BCDE;
    memImg[32'h0004_0FFC] = 32'hA001_2345;  // read only
    memImg[32'h0004_1000] = 32'hC000_0777;  // NS clear
    memImg[32'h0005_0014] = 32'h6000_0999;  // no read

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1 reqReady after reset", {31'h0, reqReady}, 32'h1);
    check(rspValid == 1'b0, "R1 rspValid after reset", {31'h0, rspValid}, 32'h0);
    check(memRdEn == 1'b0, "R1 memRdEn after reset", {31'h0, memRdEn}, 32'h0);
    walk(32'h0040_5123, 2'd0, 1'b0, f, p, n, first);
    check(f == 1'b1, "R1 R3 unset base faults", {31'h0, f}, 32'h1);
    check(n == 0, "R3 no read on zero base", n, 0);

    setBase(2'd0, 32'hE000_0010);
    setBase(2'd1, 32'hE000_0020);
    setBase(2'd2, 32'h8000_0030);

    // vector table: R4 R5 R6 R7 R8 R3
    for (int i = 0; i < NVEC; i++) begin
      walk(VEC[i].va, VEC[i].asid, VEC[i].wr, f, p, n, first);
      check(f == VEC[i].fault, $sformatf("R5 R7 R8 vec %0d fault", i), {31'h0, f}, {31'h0, VEC[i].fault});
      check(p == VEC[i].phys, $sformatf("R7 R9 vec %0d phys", i), p, VEC[i].phys);
      check(n == int'(VEC[i].nRd), $sformatf("R3 R5 R8 vec %0d read count", i), n, VEC[i].nRd);
      if (VEC[i].nRd >= 1)
        check(rdLog[first % 64] == VEC[i].rd0, $sformatf("R4 vec %0d dir address", i),
              rdLog[first % 64], VEC[i].rd0);
      if (VEC[i].nRd >= 2)
        check(rdLog[(first + 1) % 64] == VEC[i].rd1, $sformatf("R6 vec %0d table address", i),
              rdLog[(first + 1) % 64], VEC[i].rd1);
    end

    // R10 slow memory
    memWait = 3;
    walk(32'h007F_FFFF, 2'd0, 1'b0, f, p, n, first);
    check(f == 1'b0 && p == 32'h1234_5FFF, "R10 slow memory result", p, 32'h1234_5FFF);
    check(n == 2, "R10 slow memory read count", n, 2);
    memWait = 0;

    // R2 select-only write leaves bases alone
    cfgWrite(1'b0, 32'hFFFF_FFF1);
    walk(32'h0040_5123, 2'd1, 1'b1, f, p, n, first);
    check(f == 1'b0 && p == 32'h0099_9123, "R2 select write keeps base", p, 32'h0099_9123);
    // R2 data write touches only selected space
    cfgWrite(1'b1, 32'h0);
    walk(32'h0040_5123, 2'd1, 1'b1, f, p, n, first);
    check(f == 1'b1 && n == 0, "R2 R3 cleared base faults", {31'h0, f}, 32'h1);
    walk(32'h0040_5123, 2'd0, 1'b0, f, p, n, first);
    check(f == 1'b0 && p == 32'hABCD_E123, "R2 other space unchanged", p, 32'hABCD_E123);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule